// File: doc/BRIEF.md
# Memory Operation Ordering Checker

This block sits beside the load and store buffers of an out-of-order core and decides, every cycle, which buffered memory operations may touch memory. Operations enter a circular list in program order, each tagged as a load or a store. Their effective addresses arrive later, always in program order: each resolution writes into the oldest entry that still lacks an address. From the list contents the block raises one grant bit per entry.

An entry is granted when it holds an address, has not yet completed, and no older uncompleted operation conflicts with it. A load conflicts with an older store at the same address. A store conflicts with an older load or store at the same address. Two loads never conflict, and operations at different addresses never conflict, so they may run out of order. When the memory side finishes a granted access, it reports completion for that entry. Completed entries leave the list from the oldest end, one per cycle. When every slot is occupied, new allocations are refused.

Top module: `mo_order_unit`

## Requirements
- R1: After reset all grant bits are 0, `alloc_ready` is 1 and `alloc_idx` is 0.
- R2: An accepted allocation (`alloc_valid` high while `alloc_ready` is high) takes slot `alloc_idx`, and the next slot index follows modulo DEPTH. `alloc_store` = 1 marks a store and 0 marks a load. `alloc_ready` is 0 while DEPTH entries are held, and an allocation request made then is ignored.
- R3: Each `res_valid` pulse stores `res_addr` into the oldest held entry without an address. A pulse while every held entry already has an address is ignored.
- R4: No grant is given to a free slot, to an entry without an address, or to a completed entry.
- R5: A load is held back by any older uncompleted store with an equal address. It is not held back by older loads with an equal address.
- R6: A store is held back by any older uncompleted load or store with an equal address.
- R7: Older operations whose addresses differ over the full ADDR_W bits do not hold back a younger one, and neither do completed older operations.
- R8: `done_valid` with `done_idx` marks that entry completed only if its grant bit is high in that cycle; otherwise the request is ignored.
- R9: The oldest entry is freed one clock after it is completed, or later. At most one entry is freed per cycle, and only from the oldest end.
- R10: Age ordering holds across index wrap-around: after the list wraps, slot 0 can be younger than slot 3.
- R11: Grants are combinational from registered state and change one clock after the allocation, resolution or completion that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate the next entry |
| alloc_store | input | 1 | 1 for a store, 0 for a load |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | $clog2(DEPTH) | Slot the next allocation takes |
| res_valid | input | 1 | Effective address of the oldest unresolved entry is present |
| res_addr | input | ADDR_W | That effective address |
| done_valid | input | 1 | Memory access of an entry has finished |
| done_idx | input | $clog2(DEPTH) | Slot whose access finished |
| grant | output | DEPTH | Per-slot permission to access memory |

## Verification
The bench targets a load behind a same-address store and a store behind a same-address load. A design that ignored the operation type would wrongly release the load, or would wrongly block a load behind an equal-address load. Completion reported for an entry without a grant must be ignored: a design that accepted it would later drop that entry's grant. The bench also checks ordering after the list wraps, where a plain index compare would misjudge age. It checks that a full list and a resolution with nothing pending change nothing, because a design that moved a pointer there would place later addresses in the wrong slot.

// File: rtl/mo_pkg.sv
// Shared definitions for the memory operation ordering unit.
// Assumes nothing beyond the operation kinds used by the list.
package mo_pkg;
    typedef enum logic {
        MO_LOAD  = 1'b0,
        MO_STORE = 1'b1
    } mo_kind_e;
endpackage

// File: rtl/mo_ptrs.sv
// Circular list pointers: oldest entry, next free slot and next entry awaiting
// an address. Assumes DEPTH is a power of two and that the caller only requests
// a retire when the oldest entry is held and completed.
module mo_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             res_req,
    input  logic             retire_req,
    output logic             alloc_fire,
    output logic             res_fire,
    output logic             full,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [IDX_W-1:0] res_idx
);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] head_q, tail_q, rptr_q;
    logic [PTR_W-1:0] occ;

    // Occupancy and handshake decisions
    always_comb begin
        occ        = tail_q - head_q;
        full       = (occ == PTR_W'(DEPTH));
        alloc_fire = alloc_req && !full;
        res_fire   = res_req && (rptr_q != tail_q);
        head_idx   = head_q[IDX_W-1:0];
        tail_idx   = tail_q[IDX_W-1:0];
        res_idx    = rptr_q[IDX_W-1:0];
    end

    // Pointer advance, each by at most one slot per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            rptr_q <= '0;
        end else begin
            if (alloc_fire) tail_q <= tail_q + 1'b1;
            if (res_fire)   rptr_q <= rptr_q + 1'b1;
            if (retire_req) head_q <= head_q + 1'b1;
        end
    end

    p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(DEPTH));

    p_res_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(rptr_q - head_q)) <= occ);

    p_retire_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retire_req |-> (occ != '0));
endmodule

// File: rtl/mo_grant.sv
// Per-slot grant: an entry may access memory when it holds an address, is not
// completed, and no older uncompleted entry at the same address conflicts
// (store vs anything, or load vs older store). Age is taken relative to the
// oldest slot, so it stays correct across index wrap-around.
module mo_grant #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             ent_valid,
    input  logic [DEPTH-1:0]             ent_store,
    input  logic [DEPTH-1:0]             ent_addr_v,
    input  logic [DEPTH-1:0]             ent_done,
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
    input  logic [IDX_W-1:0]             head_idx,
    output logic [DEPTH-1:0]             grant
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [IDX_W-1:0] age_i;
        logic             blocked;

        // Scan all older slots for a missing address or a conflicting access
        always_comb begin
            age_i   = IDX_W'(i) - head_idx;
            blocked = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                logic [IDX_W-1:0] age_j;
                age_j = IDX_W'(j) - head_idx;
                if (j != i && ent_valid[j] && age_j < age_i && !ent_done[j]) begin
                    if (!ent_addr_v[j])
                        blocked = 1'b1;
                    else if (ent_addr[j] == ent_addr[i] && (ent_store[i] || ent_store[j]))
                        blocked = 1'b1;
                end
            end
            grant[i] = ent_valid[i] && ent_addr_v[i] && !ent_done[i] && !blocked;
        end

        for (genvar k = i + 1; k < DEPTH; k++) begin : g_pair
            p_no_pair_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[i] && grant[k] && (ent_store[i] || ent_store[k]))
                    |-> (ent_addr[i] != ent_addr[k]));
        end
    end
endmodule

// File: rtl/mo_order_unit.sv
// Memory operation ordering unit: holds in-flight loads and stores in program
// order and grants memory access per slot. Assumes addresses are supplied in
// program order and completion is reported only after a grant was used.
module mo_order_unit #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_store,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic              done_valid,
    input  logic [IDX_W-1:0]  done_idx,
    output logic [DEPTH-1:0]  grant
);
    import mo_pkg::*;

    logic [DEPTH-1:0]             valid_q, store_q, addr_v_q, done_q;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic                         alloc_fire, res_fire, full, retire, done_fire;
    logic [IDX_W-1:0]             head_idx, tail_idx, res_idx;

    // Retire and completion acceptance
    always_comb begin
        retire      = valid_q[head_idx] && done_q[head_idx];
        done_fire   = done_valid && grant[done_idx];
        alloc_ready = !full;
        alloc_idx   = tail_idx;
    end

    mo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_valid),
        .res_req    (res_valid),
        .retire_req (retire),
        .alloc_fire (alloc_fire),
        .res_fire   (res_fire),
        .full       (full),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .res_idx    (res_idx)
    );

    // Entry state: allocate, resolve, complete and free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            addr_v_q <= '0;
            done_q   <= '0;
        end else begin
            if (alloc_fire) begin
                valid_q[tail_idx]  <= 1'b1;
                store_q[tail_idx]  <= (alloc_store == MO_STORE);
                addr_v_q[tail_idx] <= 1'b0;
                done_q[tail_idx]   <= 1'b0;
            end
            if (res_fire) begin
                addr_v_q[res_idx] <= 1'b1;
                addr_q[res_idx]   <= res_addr;
            end
            if (done_fire) done_q[done_idx] <= 1'b1;
            if (retire) begin
                valid_q[head_idx]  <= 1'b0;
                addr_v_q[head_idx] <= 1'b0;
                done_q[head_idx]   <= 1'b0;
            end
        end
    end

    mo_grant #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_valid  (valid_q),
        .ent_store  (store_q),
        .ent_addr_v (addr_v_q),
        .ent_done   (done_q),
        .ent_addr   (addr_q),
        .head_idx   (head_idx),
        .grant      (grant)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_chk
        p_done_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done_q[i]) |-> $past(grant[i]));
    end
endmodule

// File: tb/tb_mo_order_unit.sv
`timescale 1ns/1ps
module tb_mo_order_unit;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              alloc_valid, alloc_store, alloc_ready;
    logic [IDX_W-1:0]  alloc_idx;
    logic              res_valid;
    logic [ADDR_W-1:0] res_addr;
    logic              done_valid;
    logic [IDX_W-1:0]  done_idx;
    logic [DEPTH-1:0]  grant;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mo_order_unit #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .res_valid(res_valid), .res_addr(res_addr),
        .done_valid(done_valid), .done_idx(done_idx),
        .grant(grant)
    );

    // Row: {kind[1:0], store, addr[15:0], idx[1:0], exp_grant[3:0], exp_ready}
    // kind: 0 idle, 1 allocate, 2 resolve address, 3 report completion
    localparam int NV = 22;
    localparam logic [25:0] VEC [0:NV-1] = '{
        {2'd1, 1'b0, 16'h0000, 2'd0, 4'b0000, 1'b1}, // 1  R2 load slot0
        {2'd1, 1'b1, 16'h0000, 2'd0, 4'b0000, 1'b1}, // 2  R2 store slot1
        {2'd1, 1'b0, 16'h0000, 2'd0, 4'b0000, 1'b1}, // 3  R4 load slot2, no addr
        {2'd2, 1'b0, 16'h0010, 2'd0, 4'b0001, 1'b1}, // 4  R3 slot0 @10
        {2'd2, 1'b0, 16'h0020, 2'd0, 4'b0011, 1'b1}, // 5  R7 store @20 past load @10
        {2'd2, 1'b0, 16'h0020, 2'd0, 4'b0011, 1'b1}, // 6  R5 load @20 behind store @20
        {2'd3, 1'b0, 16'h0000, 2'd1, 4'b0101, 1'b1}, // 7  R7 store done frees load
        {2'd1, 1'b1, 16'h0000, 2'd0, 4'b0101, 1'b0}, // 8  R2 store slot3, full
        {2'd2, 1'b0, 16'h0010, 2'd0, 4'b0101, 1'b0}, // 9  R6 store @10 behind load @10
        {2'd3, 1'b0, 16'h0000, 2'd0, 4'b1100, 1'b0}, // 10 R7 completed load no block
        {2'd0, 1'b0, 16'h0000, 2'd0, 4'b1100, 1'b1}, // 11 R9 slot0 freed
        {2'd0, 1'b0, 16'h0000, 2'd0, 4'b1100, 1'b1}, // 12 R9 slot1 freed
        {2'd1, 1'b0, 16'h0000, 2'd0, 4'b1100, 1'b1}, // 13 R10 load wraps to slot0
        {2'd2, 1'b0, 16'h0010, 2'd0, 4'b1100, 1'b1}, // 14 R10 slot0 younger than store slot3
        {2'd1, 1'b0, 16'h0000, 2'd0, 4'b1100, 1'b0}, // 15 R2 load slot1, full
        {2'd2, 1'b0, 16'h0020, 2'd0, 4'b1110, 1'b0}, // 16 R5 load-load same addr ok
        {2'd1, 1'b1, 16'h0000, 2'd0, 4'b1110, 1'b0}, // 17 R2 alloc while full ignored
        {2'd3, 1'b0, 16'h0000, 2'd0, 4'b1110, 1'b0}, // 18 R8 done on ungranted slot0
        {2'd3, 1'b0, 16'h0000, 2'd3, 4'b0111, 1'b0}, // 19 R8 slot0 still live
        {2'd3, 1'b0, 16'h0000, 2'd2, 4'b0011, 1'b0}, // 20 R4 completed not granted
        {2'd0, 1'b0, 16'h0000, 2'd0, 4'b0011, 1'b1}, // 21 R9 slot2 freed
        {2'd0, 1'b0, 16'h0000, 2'd0, 4'b0011, 1'b1}  // 22 R9 slot3 freed
    };

    task automatic idle_inputs();
        alloc_valid = 1'b0; alloc_store = 1'b0;
        res_valid = 1'b0; res_addr = '0;
        done_valid = 1'b0; done_idx = '0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive, wait one rising edge, sample at next fall
    task automatic apply(input logic [1:0] kind, input logic st, input logic [15:0] a,
                         input logic [1:0] idx);
        alloc_valid = (kind == 2'd1);
        alloc_store = st;
        res_valid   = (kind == 2'd2);
        res_addr    = {16'h0, a};
        done_valid  = (kind == 2'd3);
        done_idx    = idx;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 grant", 32'(grant), 32'h0);
        check("R1 ready", 32'(alloc_ready), 32'h1);
        check("R1 idx", 32'(alloc_idx), 32'h0);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][25:24], VEC[k][23], VEC[k][22:7], VEC[k][6:5]);
            check($sformatf("R11 row%0d grant", k + 1), 32'(grant), 32'(VEC[k][4:1]));
            check($sformatf("R2 row%0d ready", k + 1), 32'(alloc_ready), 32'(VEC[k][0]));
        end

        // R3: resolution with nothing pending is ignored; next slot index is 2
        check("R2 next idx", 32'(alloc_idx), 32'h2);
        apply(2'd2, 1'b0, 16'h0010, 2'd0);
        check("R3 idle resolve grant", 32'(grant), 32'h3);
        apply(2'd1, 1'b1, 16'h0000, 2'd0);
        check("R4 unresolved store", 32'(grant), 32'h3);
        apply(2'd2, 1'b0, 16'h0030, 2'd0);
        check("R3 store @30 resolved", 32'(grant), 32'h7);
        check("R2 idx after wrap", 32'(alloc_idx), 32'h3);

        // R1 reset in mid-flight clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 grant after reset", 32'(grant), 32'h0);
        check("R1 ready after reset", 32'(alloc_ready), 32'h1);
        check("R1 idx after reset", 32'(alloc_idx), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule